// File: doc/BRIEF.md
# Dual-Rail Fault Plane Classifier

This block sits beside a programmable AND/OR array that computes each function in dual-rail form, a true rail and a complement rail. When a checker flags an output pair as broken, a control sequence programs two spare outputs with the same function as the broken pair. It then hands both pairs to this block. The block compares the broken pattern against the spare pattern. It decides whether the fault is in the AND plane or the OR plane, whether a crosspoint was inserted or deleted, and, for an OR-plane fault, which rail is bad.

Each request passes through a valid/ready handshake. The verdict is held in a register until the controller acknowledges it. With the verdict comes a next-step code:

- an insertion search over the product lines,
- a deletion search over the product lines,
- replacement of output lines, or
- nothing further.

Programming the spare outputs and running the array belong to the surrounding controller.

Top module: `fault_plane_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `res_valid` is 0 and `req_ready` is 1.
- R2: A faulty pair that is complementary (01 or 10) gives class 0 (no fault), step 0 (none), `res_and_flag` 0 and `res_rail` 0. Bit 1 of each pair is the true rail and bit 0 is the complement rail.
- R3: A faulty pair of 00 equal to the spare pair gives class 1 (AND-plane insertion), step 1 (insertion search) and `res_and_flag` 1. A faulty pair of 11 equal to the spare pair gives class 2 (AND-plane deletion), step 2 (deletion search) and `res_and_flag` 1.
- R4: A faulty pair of 11 or 00 with a complementary spare pair gives, respectively, class 3 (OR-plane insertion) or class 4 (OR-plane deletion). Both give step 3 (replace line) and `res_and_flag` 0.
- R5: For classes 3 and 4, `res_rail` is 0 when the true rail differs from the spare true rail, and 1 when the complement rail differs. For every other class it is 0.
- R6: A faulty pair of 00 with spare 11, or 11 with spare 00, gives class 5 (both lines faulty), step 3 and `res_and_flag` 1.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `res_valid` is 1, `req_ready` is 0, and the result is stable until acknowledged.
- R8: A request presented while `res_valid` is 1 is ignored, and the held result does not change.
- R9: `res_ack` high while `res_valid` is 1 clears `res_valid` on the next cycle, and `req_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request carries a pair to classify |
| req_ready | output | 1 | Block can accept a request |
| flt_pair | input | 2 | Faulty output pair, {true, complement} |
| spr_pair | input | 2 | Spare pair programmed to the same function |
| res_valid | output | 1 | Held result is available |
| res_ack | input | 1 | Controller consumes the result |
| res_class | output | 4 | Fault class code |
| res_rail | output | 1 | Faulty rail index for OR-plane classes |
| res_step | output | 2 | Next-step code |
| res_and_flag | output | 1 | An AND-plane fault is present |

## Verification
The assertions check the handshake on every cycle:

- acceptance raises the result,
- an unacknowledged result stays stable even when new requests arrive,
- an acknowledgement clears the result.

They also check consistency between the class and the step code, the AND flag and the rail index. Whether each of the sixteen faulty/spare combinations maps to the right class and rail can only be shown by the bench's exhaustive sweep. The bench computes the expected verdict from the rail values with arithmetic.

// File: rtl/fpc_pkg.sv
// Package: shared codes and the result record of the fault plane classifier.
// Assumes pair bit 1 is the true rail and bit 0 the complement rail.
package fpc_pkg;

    localparam int CLASS_W = 4;
    localparam int STEP_W  = 2;
    localparam int PAIR_W  = 2;

    typedef enum logic [CLASS_W-1:0] {
        CLS_NONE    = 4'd0,
        CLS_AND_INS = 4'd1,
        CLS_AND_DEL = 4'd2,
        CLS_OR_INS  = 4'd3,
        CLS_OR_DEL  = 4'd4,
        CLS_BOTH    = 4'd5,
        CLS_UNCL    = 4'd15
    } fault_class_e;

    typedef enum logic [STEP_W-1:0] {
        STEP_NONE     = 2'd0,
        STEP_INS_SRCH = 2'd1,
        STEP_DEL_SRCH = 2'd2,
        STEP_REPLACE  = 2'd3
    } next_step_e;

    typedef enum logic [1:0] {
        PK_DUAL = 2'd0,
        PK_ZERO = 2'd1,
        PK_ONE  = 2'd2
    } pair_kind_e;

    typedef struct packed {
        fault_class_e cls;
        logic         rail;
        next_step_e   step;
        logic         and_flag;
    } verdict_t;

endpackage

// File: rtl/fpc_pair_kind.sv
// Module: sorts one rail pair into complementary, all-zero or all-one.
// Assumes a two-bit pair; purely combinational.
module fpc_pair_kind
    import fpc_pkg::*;
(
    input  logic [PAIR_W-1:0] pair,
    output pair_kind_e        kind
);

    // Map the rail values onto a pattern kind.
    always_comb begin
        if (pair[1] != pair[0])
            kind = PK_DUAL;
        else if (pair[1])
            kind = PK_ONE;
        else
            kind = PK_ZERO;
    end

endmodule

// File: rtl/fpc_decide.sv
// Module: applies the plane and fault-type rules to one faulty/spare pair.
// Assumes the pair kinds come from fpc_pair_kind; purely combinational.
module fpc_decide
    import fpc_pkg::*;
(
    input  logic [PAIR_W-1:0] flt_pair,
    input  logic [PAIR_W-1:0] spr_pair,
    input  pair_kind_e        flt_kind,
    input  pair_kind_e        spr_kind,
    output verdict_t          verdict
);

    // Choose the class, rail, step and AND flag from the two patterns.
    always_comb begin
        verdict.cls      = CLS_NONE;
        verdict.rail     = 1'b0;
        verdict.step     = STEP_NONE;
        verdict.and_flag = 1'b0;
        if (flt_kind == PK_DUAL) begin
            verdict.cls = CLS_NONE;
        end else if (flt_pair == spr_pair) begin
            verdict.and_flag = 1'b1;
            if (flt_kind == PK_ZERO) begin
                verdict.cls  = CLS_AND_INS;
                verdict.step = STEP_INS_SRCH;
            end else begin
                verdict.cls  = CLS_AND_DEL;
                verdict.step = STEP_DEL_SRCH;
            end
        end else if (spr_kind == PK_DUAL) begin
            verdict.cls  = (flt_kind == PK_ONE) ? CLS_OR_INS : CLS_OR_DEL;
            verdict.step = STEP_REPLACE;
            verdict.rail = (flt_pair[1] != spr_pair[1]) ? 1'b0 : 1'b1;
        end else if (flt_pair == ~spr_pair) begin
            verdict.cls      = CLS_BOTH;
            verdict.step     = STEP_REPLACE;
            verdict.and_flag = 1'b1;
        end else begin
            verdict.cls = CLS_UNCL;
        end
    end

endmodule

// File: rtl/fpc_hold.sv
// Module: result register with request acceptance and acknowledge release.
// Assumes one outstanding result; requests arriving while full are dropped.
module fpc_hold
    import fpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    output logic     req_ready,
    input  verdict_t verdict_in,
    input  logic     res_ack,
    output logic     res_valid,
    output verdict_t verdict_q
);

    logic accept;

    // Ready only while no result is waiting.
    assign req_ready = ~res_valid;
    assign accept    = req_valid & req_ready;

    // Capture on acceptance, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid          <= 1'b0;
            verdict_q.cls      <= CLS_NONE;
            verdict_q.rail     <= 1'b0;
            verdict_q.step     <= STEP_NONE;
            verdict_q.and_flag <= 1'b0;
        end else if (accept) begin
            res_valid <= 1'b1;
            verdict_q <= verdict_in;
        end else if (res_valid && res_ack) begin
            res_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fault_plane_classifier.sv
// Module: top of the classifier; kinds both pairs, decides, holds the result.
// Assumes the spare pair is already programmed with the faulty function.
module fault_plane_classifier
    import fpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  flt_pair,
    input  logic [1:0]  spr_pair,
    output logic        res_valid,
    input  logic        res_ack,
    output logic [3:0]  res_class,
    output logic        res_rail,
    output logic [1:0]  res_step,
    output logic        res_and_flag
);

    localparam int NUM_PAIRS = 2;

    logic [PAIR_W-1:0] pairs [NUM_PAIRS];
    pair_kind_e        kinds [NUM_PAIRS];
    verdict_t          verdict_c;
    verdict_t          verdict_q;

    assign pairs[0] = flt_pair;
    assign pairs[1] = spr_pair;

    // One pattern sorter per incoming pair.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_kind
        fpc_pair_kind u_kind (
            .pair (pairs[g]),
            .kind (kinds[g])
        );
    end

    fpc_decide u_decide (
        .flt_pair (flt_pair),
        .spr_pair (spr_pair),
        .flt_kind (kinds[0]),
        .spr_kind (kinds[1]),
        .verdict  (verdict_c)
    );

    fpc_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .verdict_in (verdict_c),
        .res_ack    (res_ack),
        .res_valid  (res_valid),
        .verdict_q  (verdict_q)
    );

    // Flatten the held record onto the ports.
    assign res_class    = verdict_q.cls;
    assign res_rail     = verdict_q.rail;
    assign res_step     = verdict_q.step;
    assign res_and_flag = verdict_q.and_flag;

endmodule

// File: rtl/fpc_chk.sv
// Module: property checker for the classifier, bound to its top.
// Assumes it sees only the top-level ports.
module fpc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] flt_pair,
    input logic [1:0] spr_pair,
    input logic       res_valid,
    input logic       res_ack,
    input logic [3:0] res_class,
    input logic       res_rail,
    input logic [1:0] res_step,
    input logic       res_and_flag
);

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (res_valid && !req_ready));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_class)
            && $stable(res_rail) && $stable(res_step) && $stable(res_and_flag)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ack) |=> (!res_valid && req_ready));

    p_dual_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (flt_pair[1] != flt_pair[0]))
            |=> (res_class == 4'd0 && res_step == 2'd0 && !res_and_flag));

    p_or_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_class == 4'd3 || res_class == 4'd4))
            |-> (res_step == 2'd3 && !res_and_flag));

    p_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class != 4'd3 && res_class != 4'd4) |-> !res_rail);

    p_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (flt_pair == ~spr_pair) && (flt_pair[1] == flt_pair[0]))
            |=> (res_class == 4'd5 && res_step == 2'd3 && res_and_flag));

    p_and_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_class == 4'd1 || res_class == 4'd2))
            |-> (res_and_flag && res_step == res_class[1:0]));

endmodule

bind fault_plane_classifier fpc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .flt_pair     (flt_pair),
    .spr_pair     (spr_pair),
    .res_valid    (res_valid),
    .res_ack      (res_ack),
    .res_class    (res_class),
    .res_rail     (res_rail),
    .res_step     (res_step),
    .res_and_flag (res_and_flag)
);

// File: tb/sim_fault_plane_classifier.sv
`timescale 1ns/1ps
module sim_fault_plane_classifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] flt_pair = 2'b00;
    logic [1:0] spr_pair = 2'b00;
    logic       res_valid;
    logic       res_ack = 1'b0;
    logic [3:0] res_class;
    logic       res_rail;
    logic [1:0] res_step;
    logic       res_and_flag;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fault_plane_classifier u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .flt_pair(flt_pair), .spr_pair(spr_pair), .res_valid(res_valid),
        .res_ack(res_ack), .res_class(res_class), .res_rail(res_rail),
        .res_step(res_step), .res_and_flag(res_and_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_result(input string req, input int ec, input int er,
                                input int es, input int ef);
        check({req, " class"}, res_class, ec);
        check({req, " rail"}, res_rail, er);
        check({req, " step"}, res_step, es);
        check({req, " and_flag"}, res_and_flag, ef);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check("R1 valid in reset", res_valid, 0);
        check("R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", res_valid, 0);
        check("R1 ready after reset", req_ready, 1);

        for (int code = 0; code < 16; code++) begin
            int ft, fc, st, sc;
            int ec, er, es, ef;
            string tag;
            ft = (code >> 3) & 1;
            fc = (code >> 2) & 1;
            st = (code >> 1) & 1;
            sc = code & 1;
            er = 0; es = 0; ef = 0;
            if (ft + fc == 1) begin
                ec = 0; tag = "R2";
            end else if (ft == st && fc == sc) begin
                ec = 1 + ft; es = ec; ef = 1; tag = "R3";
            end else if (st + sc == 1) begin
                ec = 4 - ft; es = 3; er = (ft != st) ? 0 : 1; tag = "R4/R5";
            end else begin
                ec = 5; es = 3; ef = 1; tag = "R6";
            end

            req_valid = 1'b1;
            flt_pair  = 2'(code >> 2);
            spr_pair  = 2'(code);
            @(negedge clk);
            req_valid = 1'b0;
            // R7: result visible one cycle after acceptance
            check("R7 valid after accept", res_valid, 1);
            check("R7 ready while held", req_ready, 0);
            check_result(tag, ec, er, es, ef);

            // R8: competing request while a result is held
            req_valid = 1'b1;
            flt_pair  = ~flt_pair;
            spr_pair  = 2'b11 ^ spr_pair ^ 2'b01;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
            check("R8 still valid", res_valid, 1);
            check_result("R8 held", ec, er, es, ef);

            // R9: acknowledge releases the result
            res_ack = 1'b1;
            @(negedge clk);
            res_ack = 1'b0;
            check("R9 valid cleared", res_valid, 0);
            check("R9 ready back", req_ready, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule